// File: doc/BRIEF.md
# Multichannel DAC Serial Receiver

This block takes serial audio for six DAC channels, grouped as three stereo pairs, and turns it into six parallel 24-bit twos-complement words. All channels share one bit clock and one left/right frame clock. Both clocks are sampled in the system clock domain. In stereo mode each of three data pins carries one pair. In TDM mode a single pin carries all six channels in fixed 32-bit slots. A replicate option drives the first pair's samples onto every pair. This serves very high sample rates, where only the first pair is fed.

Received words are collected in a holding bank. All six outputs then update together on a one-cycle frame strobe. Word width is selectable as 16, 20 or 24 bits. Narrow words are left-aligned in the 24-bit output.

The slot controller is a four-state machine:
- `ST_SEEK` waits after reset for the first frame start.
- `ST_CAPTURE` shifts in the data bits of the current slot.
- `ST_PAD` skips the rest of a slot. In TDM mode it moves on to the next slot when 32 bits have passed.
- `ST_COMMIT` lasts one cycle and publishes the frame.

The transitions are:
- A falling frame-clock edge enters `ST_CAPTURE` from any state.
- A rising frame-clock edge in stereo mode enters `ST_CAPTURE` for the right slot, from any state except `ST_SEEK`.
- In `ST_CAPTURE`, the last data bit leads to `ST_COMMIT` when the slot is the last of the frame, and to `ST_PAD` otherwise.
- In TDM mode, `ST_PAD` returns to `ST_CAPTURE` at the end of each slot, except the last one.
- `ST_COMMIT` always moves to `ST_PAD`.

Each bit-clock level must last at least two system clock cycles.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame is published, every output word is zero and `frame_valid` is low.
- R2: In stereo mode (`tdm_mode`=0), data pin p carries pair p. The slot taken while the frame clock is low goes to output channel 2p (left), and the slot taken while it is high goes to channel 2p+1 (right). Channel i sits at `dac_words[24i+23:24i]`, in the order L1, R1, L2, R2, L3, R3.
- R3: Data is MSB first. The bit sampled on the first rising bit-clock edge after a frame-clock transition is ignored. The MSB is the bit on the next rising edge.
- R4: `width_sel` 0 selects 16-bit words, 1 selects 20-bit words, and 2 or 3 select 24-bit words. A word is left-aligned in 24 bits with its low bits zero. Bits after the word inside a slot are ignored. The width and the mode are taken at the frame start.
- R5: In TDM mode (`tdm_mode`=1) only data pin 0 is used. A falling frame-clock edge starts the frame, and 32-bit slots follow in the order L1, R1, L2, R2, L3, R3. Rising frame-clock edges and pins 1 and 2 have no effect.
- R6: With `replicate_en` high at publish time, every left output equals channel 0 and every right output equals channel 1.
- R7: `frame_valid` is a one-cycle pulse, issued once per frame. All six words change together with it and hold otherwise. The pulse is visible after the 4th system clock rising edge that follows the bit-clock rising edge of the last data bit of the last slot (the right slot in stereo mode, the sixth slot in TDM mode).
- R8: After reset, nothing is captured until the first falling frame-clock edge. A right slot received before that edge publishes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, sampled on its rising edge |
| fclk_in | input | 1 | Left/right frame clock |
| sdata_in | input | 3 | Serial data pins, one per pair (pin 0 only in TDM) |
| tdm_mode | input | 1 | 1 selects the single-pin six-slot mode |
| replicate_en | input | 1 | 1 copies pair 1 to all pairs |
| width_sel | input | 2 | Word width code: 0=16, 1=20, 2 or 3=24 |
| dac_words | output | 144 | Six 24-bit left-aligned sample words |
| frame_valid | output | 1 | One-cycle strobe when the words update |

## Verification
The bench makes the bit clock rise on a falling system clock edge. Two synchronizer stages, the edge detector, the controller and the output register then put the strobe and the new words after the 4th rising system edge from that bit-clock edge. The send task returns exactly four falling edges after the rise, so each frame's latency check samples `frame_valid` at the one point where it must be high. The words are compared after the frame ends, since they are held until the next strobe. A monitor counts strobes, so each frame must add exactly one. Pad bits are driven as ones, and the ignored delay bit is driven as the inverted MSB, so zero-fill and bit alignment are visible.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int WORD_W = 24;

    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_PAD     = 2'd2,
        ST_COMMIT  = 2'd3
    } rx_state_t;

    // number of data bits in a word for a width code
    function automatic logic [4:0] word_bits(input logic [1:0] sel);
        logic [4:0] n;
        unique case (sel)
            2'd0:    n = 5'd16;
            2'd1:    n = 5'd20;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

    // move a right-justified word to the top of the output field
    function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] raw,
                                                     input logic [1:0]        sel);
        logic [WORD_W-1:0] v;
        unique case (sel)
            2'd0:    v = raw << 8;
            2'd1:    v = raw << 4;
            default: v = raw;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-2:0] sync_data,
    output logic         bit_rise
);

    logic [STAGES-1:0][W-1:0] pipe;
    logic                     bclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe      <= '0;
            bclk_prev <= 1'b0;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            bclk_prev <= pipe[STAGES-1][0];
        end
    end

    assign sync_data = pipe[STAGES-1][W-1:1];
    assign bit_rise  = pipe[STAGES-1][0] & ~bclk_prev;

endmodule

// File: rtl/dsr_slot_ctrl.sv
module dsr_slot_ctrl
    import dsr_pkg::*;
#(
    parameter int CHANS     = 6,
    parameter int SLOT_BITS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_rise,
    input  logic                       lr_now,
    input  logic                       tdm_mode,
    input  logic [1:0]                 width_sel,
    output logic                       shift_en,
    output logic                       store_en,
    output logic                       commit,
    output logic [$clog2(CHANS)-1:0]   slot_idx,
    output logic                       tdm_active,
    output logic [1:0]                 wsel_active
);

    localparam int BIT_IW  = $clog2(SLOT_BITS);
    localparam int SLOT_IW = $clog2(CHANS);

    rx_state_t            state, state_nx;
    logic                 lr_prev;
    logic [BIT_IW-1:0]    bitpos;
    logic [SLOT_IW-1:0]   slot;
    logic                 tdm_q;
    logic [1:0]           wsel_q;

    logic                 fall_evt, rise_evt;
    logic [4:0]           wlen;
    logic                 last_bit, last_slot, slot_end;

    assign fall_evt  = bit_rise & lr_prev & ~lr_now;
    assign rise_evt  = bit_rise & ~lr_prev & lr_now & ~tdm_q & (state != ST_SEEK);
    assign wlen      = word_bits(wsel_q);
    assign last_bit  = (bitpos == BIT_IW'(wlen - 5'd1));
    assign slot_end  = (bitpos == BIT_IW'(SLOT_BITS - 1));
    assign last_slot = tdm_q ? (slot == SLOT_IW'(CHANS - 1)) : (slot == SLOT_IW'(1));

    // next state
    always_comb begin
        state_nx = state;
        if (fall_evt || rise_evt) begin
            state_nx = ST_CAPTURE;
        end else begin
            unique case (state)
                ST_SEEK:    state_nx = ST_SEEK;
                ST_CAPTURE: if (bit_rise && last_bit)
                                state_nx = last_slot ? ST_COMMIT : ST_PAD;
                ST_PAD:     if (bit_rise && tdm_q && slot_end && !last_slot)
                                state_nx = ST_CAPTURE;
                ST_COMMIT:  state_nx = ST_PAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEEK;
        else        state <= state_nx;
    end

    // slot and bit counters, frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            bitpos  <= '0;
            slot    <= '0;
            tdm_q   <= 1'b0;
            wsel_q  <= 2'd2;
        end else begin
            if (bit_rise) lr_prev <= lr_now;
            if (fall_evt) begin
                slot   <= '0;
                bitpos <= '0;
                tdm_q  <= tdm_mode;
                wsel_q <= width_sel;
            end else if (rise_evt) begin
                slot   <= SLOT_IW'(1);
                bitpos <= '0;
            end else if (bit_rise) begin
                unique case (state)
                    ST_CAPTURE: bitpos <= bitpos + BIT_IW'(1);
                    ST_PAD: begin
                        if (tdm_q && slot_end && !last_slot) begin
                            slot   <= slot + SLOT_IW'(1);
                            bitpos <= '0;
                        end else if (!slot_end) begin
                            bitpos <= bitpos + BIT_IW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        shift_en    = bit_rise && (state == ST_CAPTURE) && !fall_evt && !rise_evt;
        store_en    = shift_en && last_bit;
        commit      = (state == ST_COMMIT);
        slot_idx    = slot;
        tdm_active  = tdm_q;
        wsel_active = wsel_q;
    end

endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter
    import dsr_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [PAIRS-1:0]          sdata,
    input  logic [1:0]                wsel,
    output logic [PAIRS*WORD_W-1:0]   aligned
);

    for (genvar p = 0; p < PAIRS; p++) begin : g_lane
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] nxt;

        assign nxt = {sh[WORD_W-2:0], sdata[p]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sh <= '0;
            else if (shift_en) sh <= nxt;
        end

        assign aligned[p*WORD_W +: WORD_W] = left_align(nxt, wsel);
    end

endmodule

// File: rtl/dsr_frame_store.sv
module dsr_frame_store
    import dsr_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          store_en,
    input  logic [$clog2(2*PAIRS)-1:0]    slot_idx,
    input  logic                          tdm_active,
    input  logic [PAIRS*WORD_W-1:0]       aligned,
    input  logic                          commit,
    input  logic                          replicate_en,
    output logic [2*PAIRS*WORD_W-1:0]     dac_words,
    output logic                          frame_valid
);

    localparam int CHANS = 2 * PAIRS;

    logic [CHANS-1:0][WORD_W-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (store_en) begin
            if (tdm_active) begin
                if (int'(slot_idx) < CHANS) hold[slot_idx] <= aligned[WORD_W-1:0];
            end else begin
                for (int p = 0; p < PAIRS; p++) begin
                    hold[2*p + int'(slot_idx[0])] <= aligned[p*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_words   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= commit;
            if (commit) begin
                for (int i = 0; i < CHANS; i++) begin
                    dac_words[i*WORD_W +: WORD_W] <= replicate_en ? hold[i % 2] : hold[i];
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import dsr_pkg::*;
#(
    parameter int PAIRS       = 3,
    parameter int SLOT_BITS   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bclk_in,
    input  logic                        fclk_in,
    input  logic [PAIRS-1:0]            sdata_in,
    input  logic                        tdm_mode,
    input  logic                        replicate_en,
    input  logic [1:0]                  width_sel,
    output logic [2*PAIRS*WORD_W-1:0]   dac_words,
    output logic                        frame_valid
);

    localparam int CHANS   = 2 * PAIRS;
    localparam int SLOT_IW = $clog2(CHANS);

    logic [PAIRS:0]         sync_data;
    logic                   bit_rise;
    logic                   shift_en, store_en, commit, tdm_active;
    logic [SLOT_IW-1:0]     slot_idx;
    logic [1:0]             wsel_active;
    logic [PAIRS*WORD_W-1:0] aligned;

    dsr_sync #(.W(PAIRS + 2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdata_in, fclk_in, bclk_in}),
        .sync_data(sync_data),
        .bit_rise (bit_rise)
    );

    dsr_slot_ctrl #(.CHANS(CHANS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bit_rise),
        .lr_now     (sync_data[0]),
        .tdm_mode   (tdm_mode),
        .width_sel  (width_sel),
        .shift_en   (shift_en),
        .store_en   (store_en),
        .commit     (commit),
        .slot_idx   (slot_idx),
        .tdm_active (tdm_active),
        .wsel_active(wsel_active)
    );

    dsr_shifter #(.PAIRS(PAIRS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .sdata   (sync_data[PAIRS:1]),
        .wsel    (wsel_active),
        .aligned (aligned)
    );

    dsr_frame_store #(.PAIRS(PAIRS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_en    (store_en),
        .slot_idx    (slot_idx),
        .tdm_active  (tdm_active),
        .aligned     (aligned),
        .commit      (commit),
        .replicate_en(replicate_en),
        .dac_words   (dac_words),
        .frame_valid (frame_valid)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk
    import dsr_pkg::*;
#(
    parameter int PAIRS = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        replicate_en,
    input logic                        frame_valid,
    input logic [2*PAIRS*WORD_W-1:0]   dac_words
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_words == '0 && !frame_valid));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_words_move_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_words) |-> frame_valid);

    for (genvar p = 1; p < PAIRS; p++) begin : g_rep
        assert_replicate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_valid && $past(replicate_en)) |->
            (dac_words[(2*p)*WORD_W +: WORD_W]   == dac_words[0 +: WORD_W] &&
             dac_words[(2*p+1)*WORD_W +: WORD_W] == dac_words[WORD_W +: WORD_W]));
    end

endmodule

bind audio_serial_rx audio_serial_rx_chk #(.PAIRS(PAIRS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .replicate_en(replicate_en),
    .frame_valid (frame_valid),
    .dac_words   (dac_words)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         fclk = 1'b0;
    logic [2:0]   sdata = 3'b000;
    logic         tdm = 1'b0;
    logic         rep = 1'b0;
    logic [1:0]   wsel = 2'd2;
    logic [143:0] words;
    logic         frame_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int vcount  = 0;

    always #10 clk = ~clk;

    audio_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fclk_in(fclk),
        .sdata_in(sdata), .tdm_mode(tdm), .replicate_en(rep),
        .width_sel(wsel), .dac_words(words), .frame_valid(frame_valid)
    );

    always @(posedge clk) if (rst_n && frame_valid) vcount <= vcount + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expw(input logic [23:0] raw, input int wb);
        logic [23:0] v;
        v = raw << (24 - wb);
        return v;
    endfunction

    // one bit: data changes with bit clock low, bit clock rises, return 4 falling clk edges later
    task automatic send_bit(input logic lr, input logic [2:0] d);
        @(negedge clk);
        bclk = 1'b0; fclk = lr; sdata = d;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic stereo_slot(input logic lr, input logic [5:0][23:0] raw, input int wb,
                               input bit lat_chk, input string tag);
        for (int i = 0; i < 32; i++) begin
            logic [2:0] d;
            for (int p = 0; p < 3; p++) begin
                logic [23:0] w;
                w = raw[2*p + int'(lr)];
                if (i == 0)       d[p] = ~w[wb-1];
                else if (i <= wb) d[p] = w[wb-i];
                else              d[p] = 1'b1;
            end
            send_bit(lr, d);
            if (lat_chk && i == wb) chk({tag, " R7 valid latency"}, {31'd0, frame_valid}, 32'd1);
        end
    endtask

    task automatic stereo_frame(input logic [5:0][23:0] raw, input int wb, input string tag);
        stereo_slot(1'b0, raw, wb, 1'b0, tag);
        stereo_slot(1'b1, raw, wb, 1'b1, tag);
    endtask

    task automatic tdm_frame(input logic [5:0][23:0] raw, input int wb, input string tag);
        send_bit(1'b0, {2'b10, ~raw[0][wb-1]});
        for (int s = 0; s < 6; s++) begin
            for (int j = 0; j < 32; j++) begin
                logic d0;
                logic [1:0] jb;
                d0 = (j < wb) ? raw[s][wb-1-j] : 1'b1;
                jb = 2'(j);
                send_bit((s == 0) ? 1'b0 : 1'b1, {jb[1], jb[0], d0});
                if (s == 5 && j == wb - 1)
                    chk({tag, " R7 valid latency"}, {31'd0, frame_valid}, 32'd1);
            end
        end
    endtask

    task automatic check_words(input logic [5:0][23:0] raw, input int wb, input bit r,
                               input int v0, input string tag);
        chk({tag, " R7 one pulse per frame"}, 32'(vcount - v0), 32'd1);
        for (int i = 0; i < 6; i++) begin
            logic [23:0] e;
            e = expw(r ? raw[i % 2] : raw[i], wb);
            chk($sformatf("%s ch%0d", tag, i), {8'd0, words[i*24 +: 24]}, {8'd0, e});
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 words in reset", {31'd0, |words}, 32'd0);
        chk("R1 valid in reset", {31'd0, frame_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 words after reset", {31'd0, |words}, 32'd0);
    endtask

    task automatic t_seek();
        logic [5:0][23:0] raw;
        int v0;
        raw = {24'h111111, 24'h222222, 24'h333333, 24'h444444, 24'h555555, 24'h666666};
        for (int i = 0; i < 4; i++) send_bit(1'b0, 3'b101);
        stereo_slot(1'b1, raw, 24, 1'b0, "R8");
        chk("R8 no frame before first falling edge", 32'(vcount), 32'd0);
        chk("R8 words untouched", {31'd0, |words}, 32'd0);
        v0 = vcount;
        stereo_frame(raw, 24, "R8 first frame");
        check_words(raw, 24, 1'b0, v0, "R8 first frame");
    endtask

    task automatic t_stereo(input int wb, input logic [1:0] code, input logic [5:0][23:0] raw,
                            input string tag);
        int v0;
        tdm = 1'b0; rep = 1'b0; wsel = code;
        v0 = vcount;
        stereo_frame(raw, wb, tag);
        check_words(raw, wb, 1'b0, v0, tag);
    endtask

    task automatic t_tdm(input int wb, input logic [1:0] code, input logic [5:0][23:0] raw,
                         input string tag);
        int v0;
        tdm = 1'b1; rep = 1'b0; wsel = code;
        v0 = vcount;
        tdm_frame(raw, wb, tag);
        check_words(raw, wb, 1'b0, v0, tag);
    endtask

    task automatic t_replicate();
        logic [5:0][23:0] raw;
        int v0;
        raw = {24'hAAAAAA, 24'h555555, 24'h0F0F0F, 24'hF0F0F0, 24'h123456, 24'hFEDCBA};
        tdm = 1'b0; rep = 1'b1; wsel = 2'd2;
        v0 = vcount;
        stereo_frame(raw, 24, "R6 stereo replicate");
        check_words(raw, 24, 1'b1, v0, "R6 stereo replicate");
        tdm = 1'b1;
        v0 = vcount;
        tdm_frame(raw, 24, "R6 tdm replicate");
        check_words(raw, 24, 1'b1, v0, "R6 tdm replicate");
        rep = 1'b0;
    endtask

    task automatic t_hold();
        logic [143:0] snap;
        int v0;
        snap = words;
        v0 = vcount;
        for (int i = 0; i < 40; i++) send_bit(1'b1, 3'(i));
        chk("R7 no pulse without frame", 32'(vcount - v0), 32'd0);
        chk("R7 words held", {31'd0, words == snap}, 32'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_seek();
        t_stereo(24, 2'd2, {24'h7FFFFF, 24'h800000, 24'h000000, 24'hC3A5E1, 24'h000001, 24'hFFFFFF},
                 "R2 R3 stereo 24 a");
        t_stereo(24, 2'd3, {24'h13579B, 24'h2468AC, 24'hDEAD01, 24'h00BEEF, 24'h808080, 24'h7F7F7F},
                 "R2 R3 stereo 24 b");
        t_stereo(16, 2'd0, {24'h007FFF, 24'h008000, 24'h00A5C3, 24'h000001, 24'h00FFFF, 24'h001234},
                 "R4 stereo 16");
        t_stereo(20, 2'd1, {24'h07FFFF, 24'h080000, 24'h0ABCDE, 24'h000010, 24'h0FFFFF, 24'h054321},
                 "R4 stereo 20");
        t_tdm(24, 2'd2, {24'h665544, 24'h332211, 24'hABCDEF, 24'h800001, 24'h7FFFFE, 24'h0F1E2D},
              "R5 tdm 24");
        t_tdm(16, 2'd0, {24'h00F00F, 24'h000FF0, 24'h008001, 24'h007FFE, 24'h00AAAA, 24'h005555},
              "R5 R4 tdm 16");
        t_replicate();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (R1..R8 run) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule